// File: doc/BRIEF.md
# Rotating Multi-Slot Write-Back Arbiter

This block sits between a set of fixed-latency result pipes and a common data bus that can carry only a limited number of results per cycle. Each pipe hands its finished instructions to a small completion queue of its own. Several pipes may finish in the same cycle. When more results are waiting than the bus can carry, the extra results stay in their queues. A queue that fills up raises a stall flag toward its pipe, so no result is ever lost.

Each cycle the arbiter walks the queues in circular order. It starts from a resume pointer. Every non-empty queue it meets hands over its oldest entry to the next free bus slot. The walk ends when all bus slots are taken or every queue has been looked at once. The resume pointer then moves to the queue just after the last one that won a slot, so the next cycle's walk picks up where this one ended. Winners are packed into the bus slots from slot 0 upward. Each winner carries its instruction tag and the index of the pipe it came from.

Top module: `wb_arbiter`

## Requirements
- R1: After reset every queue is empty, all level outputs read 0, no stall flag is raised, no write-back slot is valid, and the resume pointer selects pipe 0.
- R2: In any cycle the number of valid write-back slots is at most WB_SLOTS, and the valid slots are always a contiguous run starting at slot 0.
- R3: Each queue releases its entries in arrival order, and a slot's tag equals the oldest entry of the queue named by that slot's source index.
- R4: A queue wins at most one slot per cycle.
- R5: Slots are handed out in circular queue order starting at the resume pointer. A non-empty queue goes without a slot only when every slot is already taken.
- R6: After a cycle with at least one winner, the resume pointer moves to the queue just after the last winner (wrapping from NUM_PIPES-1 to 0). After a cycle with no winner it keeps its value.
- R7: Each pipe's level output gives the number of entries held in its queue. Its stall flag is high exactly when that level equals DEPTH.
- R8: A queue may accept an arrival and release its oldest entry in the same cycle, even when full. Its level then stays the same and no entry is lost. A pipe must not deliver to a full queue that does not win a slot in that cycle.
- R9: A result delivered at a clock edge can win a slot in the cycle right after that edge. It leaves its queue at the edge that ends the cycle in which it wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid_i | input | NUM_PIPES | Per-pipe completion strobe |
| cmp_tag_i | input | NUM_PIPES*TAG_W | Per-pipe completing tag; pipe p occupies bits [p*TAG_W +: TAG_W] |
| stall_o | output | NUM_PIPES | Per-pipe queue-full flag |
| level_o | output | NUM_PIPES*LW | Per-pipe queue occupancy, LW = bits to hold DEPTH |
| wb_valid_o | output | WB_SLOTS | Write-back slot valid, filled from slot 0 upward |
| wb_tag_o | output | WB_SLOTS*TAG_W | Tag carried on each slot |
| wb_src_o | output | WB_SLOTS*IW | Source pipe index per slot, IW = bits to index NUM_PIPES |

## Verification
The hardest case to reach is a full queue that takes a new arrival in the same cycle that it wins a slot. The level must hold at DEPTH and the queue order must survive. This needs more pipes pushing than there are bus slots for long enough that every queue fills. So the bench spends a phase with all pipes delivering every cycle, which keeps four queues full against two slots while each pipe keeps pushing whenever it is granted. Further phases sweep every push mask across the pipes and feed single pipes in isolation. They then drain to idle, so the resume pointer is seen both holding (no winner) and wrapping past the last pipe.

// File: rtl/wbarb_pkg.sv
package wbarb_pkg;

    // Bits needed to index n items; at least one bit.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Bits needed to hold the count n itself.
    function automatic int unsigned cnt_bits(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cmp_queue.sv
module cmp_queue
    import wbarb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TAG_W = 8,
    localparam int AW = idx_bits(DEPTH),
    localparam int LW = cnt_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             pop_i,
    output logic [TAG_W-1:0] head_o,
    output logic             nonempty_o,
    output logic             full_o,
    output logic [LW-1:0]    level_o
);

    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0] mem;
        logic [AW-1:0]               rd;
        logic [AW-1:0]               wr;
        logic [LW-1:0]               lvl;
    } q_st_t;

    q_st_t st_d, st_q;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            st_d.mem[st_q.wr] = tag_i;
            st_d.wr           = ptr_inc(st_q.wr);
        end
        if (pop_i) begin
            st_d.rd = ptr_inc(st_q.rd);
        end
        case ({push_i, pop_i})
            2'b10:   st_d.lvl = st_q.lvl + 1'b1;
            2'b01:   st_d.lvl = st_q.lvl - 1'b1;
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o     = st_q.mem[st_q.rd];
    assign nonempty_o = (st_q.lvl != '0);
    assign full_o     = (int'(st_q.lvl) == DEPTH);
    assign level_o    = st_q.lvl;

    // R8: a full queue only accepts when it also releases.
    p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o) |-> pop_i);

    // R3: release only from a queue holding data.
    p_pop_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (st_q.lvl != '0));

    // R7: occupancy never exceeds the queue size.
    p_level_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.lvl) <= DEPTH);

    // R8: simultaneous accept and release leaves the level unchanged.
    p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> $stable(st_q.lvl));

endmodule

// File: rtl/rr_multi_scan.sv
module rr_multi_scan
    import wbarb_pkg::*;
#(
    parameter int NUM_PIPES = 4,
    parameter int WB_SLOTS  = 2,
    localparam int IW = idx_bits(NUM_PIPES),
    localparam int SW = idx_bits(WB_SLOTS),
    localparam int UW = cnt_bits(WB_SLOTS)
) (
    input  logic [IW-1:0]        start_i,
    input  logic [NUM_PIPES-1:0] ready_i,
    output logic [NUM_PIPES-1:0] grant_o,
    output logic [WB_SLOTS-1:0]  slot_valid_o,
    output logic [IW-1:0]        slot_src_o [WB_SLOTS],
    output logic [IW-1:0]        next_start_o
);

    logic [UW-1:0] used;
    logic [IW-1:0] last;
    logic          any;
    logic [IW:0]   sum;
    logic [IW-1:0] idx;

    always_comb begin
        grant_o      = '0;
        slot_valid_o = '0;
        for (int s = 0; s < WB_SLOTS; s++) begin
            slot_src_o[s] = '0;
        end
        used = '0;
        last = start_i;
        any  = 1'b0;
        sum  = '0;
        idx  = '0;
        for (int k = 0; k < NUM_PIPES; k++) begin
            sum = {1'b0, start_i} + (IW+1)'(k);
            if (int'(sum) >= NUM_PIPES) begin
                sum = sum - (IW+1)'(NUM_PIPES);
            end
            idx = sum[IW-1:0];
            if (ready_i[idx] && (int'(used) < WB_SLOTS)) begin
                grant_o[idx]                = 1'b1;
                slot_valid_o[used[SW-1:0]]  = 1'b1;
                slot_src_o[used[SW-1:0]]    = idx;
                used                        = used + 1'b1;
                last                        = idx;
                any                         = 1'b1;
            end
        end
        if (!any) begin
            next_start_o = start_i;
        end else if (int'(last) == NUM_PIPES - 1) begin
            next_start_o = '0;
        end else begin
            next_start_o = last + 1'b1;
        end
    end

endmodule

// File: rtl/wb_arbiter.sv
module wb_arbiter
    import wbarb_pkg::*;
#(
    parameter int NUM_PIPES = 4,
    parameter int WB_SLOTS  = 2,
    parameter int DEPTH     = 4,
    parameter int TAG_W     = 8,
    localparam int IW = idx_bits(NUM_PIPES),
    localparam int LW = cnt_bits(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PIPES-1:0]      cmp_valid_i,
    input  logic [NUM_PIPES*TAG_W-1:0] cmp_tag_i,
    output logic [NUM_PIPES-1:0]      stall_o,
    output logic [NUM_PIPES*LW-1:0]   level_o,
    output logic [WB_SLOTS-1:0]       wb_valid_o,
    output logic [WB_SLOTS*TAG_W-1:0] wb_tag_o,
    output logic [WB_SLOTS*IW-1:0]    wb_src_o
);

    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [NUM_PIPES-1:0] nonempty;
    logic [NUM_PIPES-1:0] grant;
    logic [TAG_W-1:0]     head      [NUM_PIPES];
    logic [IW-1:0]        slot_src  [WB_SLOTS];
    logic [WB_SLOTS-1:0]  slot_valid;
    logic [IW-1:0]        next_ptr;

    genvar p;
    generate
        for (p = 0; p < NUM_PIPES; p++) begin : g_q
            cmp_queue #(
                .DEPTH (DEPTH),
                .TAG_W (TAG_W)
            ) i_q (
                .clk        (clk),
                .rst_n      (rst_n),
                .push_i     (cmp_valid_i[p]),
                .tag_i      (cmp_tag_i[p*TAG_W +: TAG_W]),
                .pop_i      (grant[p]),
                .head_o     (head[p]),
                .nonempty_o (nonempty[p]),
                .full_o     (stall_o[p]),
                .level_o    (level_o[p*LW +: LW])
            );
        end
    endgenerate

    rr_multi_scan #(
        .NUM_PIPES (NUM_PIPES),
        .WB_SLOTS  (WB_SLOTS)
    ) i_scan (
        .start_i      (st_q.ptr),
        .ready_i      (nonempty),
        .grant_o      (grant),
        .slot_valid_o (slot_valid),
        .slot_src_o   (slot_src),
        .next_start_o (next_ptr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ptr = next_ptr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        wb_valid_o = slot_valid;
        for (int s = 0; s < WB_SLOTS; s++) begin
            wb_src_o[s*IW +: IW]    = slot_src[s];
            wb_tag_o[s*TAG_W +: TAG_W] = slot_valid[s] ? head[slot_src[s]] : '0;
        end
    end

    // R6: the pointer holds through a cycle with no winner.
    p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |=> $stable(st_q.ptr));

    // R2: slot count matches the number of queues that won.
    p_grants_match_slots_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) == $countones(wb_valid_o));

    // R5: an idle slot implies no queue was left waiting.
    p_no_idle_with_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wb_valid_o[WB_SLOTS-1]) |-> ((nonempty & ~grant) == '0));

    genvar s, t;
    generate
        for (s = 1; s < WB_SLOTS; s++) begin : g_prefix
            // R2: valid slots form a run from slot 0.
            p_slot_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
                wb_valid_o[s] |-> wb_valid_o[s-1]);
        end
        for (s = 0; s < WB_SLOTS; s++) begin : g_pair_a
            for (t = s + 1; t < WB_SLOTS; t++) begin : g_pair_b
                // R4: two slots never come from the same queue.
                p_one_per_queue_r4: assert property (@(posedge clk) disable iff (!rst_n)
                    (wb_valid_o[s] && wb_valid_o[t]) |-> (slot_src[s] != slot_src[t]));
            end
        end
    endgenerate

endmodule

// File: tb/test_wb_arbiter.sv
`timescale 1ns/1ps
module test_wb_arbiter;

    localparam int NP = 4;
    localparam int WB = 2;
    localparam int DEPTH = 4;
    localparam int TW = 8;
    localparam int IW = 2;
    localparam int LW = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NP-1:0]      cmp_valid = '0;
    logic [NP*TW-1:0]   cmp_tag = '0;
    logic [NP-1:0]      stall;
    logic [NP*LW-1:0]   level;
    logic [WB-1:0]      wb_valid;
    logic [WB*TW-1:0]   wb_tag;
    logic [WB*IW-1:0]   wb_src;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int mq [NP][$];
    int mptr = 0;
    int tag_ctr = 1;

    always #4 clk = ~clk;

    wb_arbiter #(
        .NUM_PIPES (NP),
        .WB_SLOTS  (WB),
        .DEPTH     (DEPTH),
        .TAG_W     (TW)
    ) i_wb_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_valid_i (cmp_valid),
        .cmp_tag_i   (cmp_tag),
        .stall_o     (stall),
        .level_o     (level),
        .wb_valid_o  (wb_valid),
        .wb_tag_o    (wb_tag),
        .wb_src_o    (wb_src)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit want_push(input int mode, input int p, input int cyc, input int sel);
        case (mode)
            0: return 1'b1;
            1: return ((cyc % 16) >> p) & 1;
            2: return 1'b0;
            3: return p == sel;
            default: return ((cyc % 3) == 0) && (p == 1 || p == 3);
        endcase
    endfunction

    // One cycle: check outputs against the model at the negative edge,
    // then drive pushes and advance the model to the next edge.
    task automatic step(input int mode, input int cyc, input int sel);
        int ev [WB];
        int es [WB];
        int et [WB];
        bit gr [NP];
        int used;
        int last;
        logic [NP-1:0] pv;
        logic [NP*TW-1:0] pt;
        @(negedge clk);
        used = 0;
        last = -1;
        for (int s = 0; s < WB; s++) begin ev[s] = 0; es[s] = 0; et[s] = 0; end
        for (int p = 0; p < NP; p++) gr[p] = 0;
        for (int k = 0; k < NP; k++) begin
            int idx;
            idx = (mptr + k) % NP;
            if (mq[idx].size() > 0 && used < WB) begin
                ev[used] = 1;
                es[used] = idx;
                et[used] = mq[idx][0];
                gr[idx] = 1;
                used++;
                last = idx;
            end
        end
        for (int s = 0; s < WB; s++) begin
            // R2 R5: slot valid pattern from rotating scan
            chk(wb_valid[s] == ev[s], "R2/R5 slot valid", int'(wb_valid[s]), ev[s]);
            if (ev[s] != 0) begin
                // R5 R6: source order follows resume pointer
                chk(int'(wb_src[s*IW +: IW]) == es[s], "R5/R6 slot source",
                    int'(wb_src[s*IW +: IW]), es[s]);
                // R3 R9: oldest tag of the queue
                chk(int'(wb_tag[s*TW +: TW]) == et[s], "R3/R9 slot tag",
                    int'(wb_tag[s*TW +: TW]), et[s]);
            end
        end
        for (int p = 0; p < NP; p++) begin
            chk(int'(level[p*LW +: LW]) == mq[p].size(), "R7 level",
                int'(level[p*LW +: LW]), mq[p].size());
            chk(stall[p] == (mq[p].size() == DEPTH), "R7 stall",
                int'(stall[p]), int'(mq[p].size() == DEPTH));
        end
        pv = '0;
        pt = '0;
        for (int p = 0; p < NP; p++) begin
            if (want_push(mode, p, cyc, sel) && (mq[p].size() < DEPTH || gr[p])) begin
                pv[p] = 1'b1;
                pt[p*TW +: TW] = TW'(tag_ctr);
            end
            if (gr[p]) void'(mq[p].pop_front());
            if (pv[p]) begin
                mq[p].push_back(tag_ctr);
                tag_ctr = (tag_ctr % 255) + 1;
            end
        end
        if (last >= 0) mptr = (last + 1) % NP;
        cmp_valid = pv;
        cmp_tag = pt;
    endtask

    task automatic phase(input int mode, input int n, input int sel);
        for (int c = 0; c < n; c++) step(mode, c, sel);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(wb_valid == '0, "R1 no slot valid", int'(wb_valid), 0);
        chk(level == '0, "R1 levels zero", int'(level), 0);
        chk(stall == '0, "R1 no stall", int'(stall), 0);
        // R1 R6: single pushes to pipes 3 and 1 reveal pointer starting at 0
        phase(4, 1, 0);
        // R9: results appear the cycle after delivery
        phase(2, 3, 0);
        // R8: saturate all queues, full queues accept while releasing
        phase(0, 60, 0);
        phase(2, 20, 0);
        // R2 R4 R5: sweep every push mask
        phase(1, 64, 0);
        phase(2, 12, 0);
        // R6: a single source, pointer wraps past it
        for (int q = 0; q < NP; q++) begin
            phase(3, 9, q);
            phase(2, 6, 0);
        end
        phase(4, 30, 0);
        phase(2, 12, 0);
        phase(0, 25, 0);
        phase(2, 25, 0);
        @(negedge clk);
        chk(level == '0, "R7 drained", int'(level), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule